// File: doc/BRIEF.md
# Status register and write-protection unit

This block holds the 8-bit status byte of a serial EEPROM and decides whether writes to the memory array and to the status byte may go ahead. A command sequencer, which is not part of this block, decodes the serial instructions. It passes in single-cycle strobes for write enable, write disable, a status-write request with its data byte, an array-write start and the end of the self-timed cycle. It also passes in the target array address. The block also samples the active-low write-protect pin.

The block returns the status byte, which can be read at any moment. It also returns two permits: one for an array write at the presented address and one for a status write. The sequencer uses the permits to decide whether an instruction is started. Start strobes that arrive while a permit is low are dropped inside the block.

Protection has two layers. Two block-select bits mark a fixed top region of the array as read-only. The region is the upper quarter, the upper half or the whole array. A status-lock bit, taken together with a low write-protect pin, freezes the status byte itself. The non-volatile bits are plain registers that reset to zero. A status write changes them only when its cycle ends, so the old protection stays in force while the cycle runs.

Top module: `sr_wprot`

## Requirements
- R1: The status byte is {lock, 0, 0, 0, blk[1], blk[0], latch, busy}, with bit 7 the lock bit, bits 6..4 always 0, bits 3..2 the block-select bits, bit 1 the write-enable latch and bit 0 write-in-progress. After reset it reads 8'h00 and both permits are 0.
- R2: A write-enable strobe sets the latch on the next edge unless a cycle is running. A write-disable strobe clears it. If both strobes come together, disable wins.
- R3: The status-write permit is 1 only when the latch is set, no cycle is running, and hardware protection is off. Hardware protection is on when the lock bit is 1 and wp_ni is 0, whichever of the two happened first.
- R4: An accepted status write sets busy. Bits 7, 3 and 2 keep their old values until the cycle-end strobe, and then take data bits 7, 3 and 2. All other data bits have no effect.
- R5: A status-write request made while the status-write permit is 0 is ignored: the status byte and busy do not change.
- R6: The array-write permit needs the latch set and no cycle running. It also needs the address to lie outside the protected region. The region follows blk: 00 protects nothing, 01 protects C000h..FFFFh, 10 protects 8000h..FFFFh, and 11 protects the whole array.
- R7: An array-write start sets busy only while the array-write permit is 1, and is otherwise ignored. A status write accepted in the same cycle takes priority.
- R8: A cycle-end strobe while busy clears busy and the latch on the same edge. While idle, the strobe has no effect.
- R9: Hardware protection ends only when wp_ni goes high. With the lock bit still 1 and the latch set, the status-write permit then returns to 1.
- R10: The busy bit reads 1 from the edge that accepts a write until the end-of-cycle edge, and the status byte is readable throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| sr_wr_req_i | input | 1 | Status-write request strobe |
| sr_wr_data_i | input | 8 | Data byte of the status write |
| arr_start_i | input | 1 | Array-write cycle start strobe |
| cyc_done_i | input | 1 | Self-timed cycle end strobe |
| addr_i | input | ADDR_W | Target array address |
| wp_ni | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array write permitted at addr_i |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The assertions assume that every strobe is synchronous to clk_i and lasts one cycle. They also assume that a start strobe reaches the cycle controller only once the top-level permit has gated it, so an accepted start always finds the latch set and the block idle. The bench changes inputs only at the falling edge. It holds addr_i and wp_ni steady across the edge being checked, and it issues a cycle-end strobe only after a start it expects to be accepted, apart from one deliberate strobe sent while idle.

// File: rtl/sr_wprot_pkg.sv
package sr_wprot_pkg;
  localparam int SR_W     = 8;
  localparam int LOCK_BIT = 7;
  localparam int BLK_HI   = 3;
  localparam int BLK_LO   = 2;

  typedef enum logic [1:0] {
    BLK_NONE    = 2'b00,
    BLK_QUARTER = 2'b01,
    BLK_HALF    = 2'b10,
    BLK_ALL     = 2'b11
  } blk_sel_e;

  typedef enum logic {
    CYC_ARRAY  = 1'b0,
    CYC_STATUS = 1'b1
  } cyc_kind_e;

  typedef struct packed {
    logic     lock;
    blk_sel_e blk;
  } nv_bits_t;
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
  import sr_wprot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  blk_sel_e          blk_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  logic upper_half, upper_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign upper_half    = addr_i[TOP];
      assign upper_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign upper_half    = addr_i[TOP];
      assign upper_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (blk_i)
      BLK_NONE:    hit_o = 1'b0;
      BLK_QUARTER: hit_o = upper_quarter;
      BLK_HALF:    hit_o = upper_half;
      default:     hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_cycle_ctrl.sv
module sr_cycle_ctrl
  import sr_wprot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic sr_go_i,
  input  logic arr_go_i,
  input  logic done_i,
  output logic wip_o,
  output logic wel_o,
  output logic commit_o
);
  logic      wip_q, wel_q;
  cyc_kind_e kind_q;
  logic      finish;

  assign finish = wip_q & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q  <= 1'b0;
      kind_q <= CYC_ARRAY;
    end else if (wip_q) begin
      if (done_i) wip_q <= 1'b0;
    end else if (sr_go_i) begin
      wip_q  <= 1'b1;
      kind_q <= CYC_STATUS;
    end else if (arr_go_i) begin
      wip_q  <= 1'b1;
      kind_q <= CYC_ARRAY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wel_q <= 1'b0;
    else if (finish || wrdi_i)  wel_q <= 1'b0;
    else if (wren_i && !wip_q)  wel_q <= 1'b1;
  end

  assign commit_o = finish & (kind_q == CYC_STATUS);
  assign wip_o    = wip_q;
  assign wel_o    = wel_q;

  assert_done_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_q && done_i) |=> (!wip_q && !wel_q));
  assert_wrdi_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i |=> !wel_q);
  assert_wren_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !wrdi_i && !wip_q) |=> wel_q);
  assert_go_needs_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_go_i || arr_go_i) |-> (wel_q && !wip_q));
  assert_busy_from_go_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(sr_go_i || arr_go_i));
endmodule

// File: rtl/sr_nv_bits.sv
module sr_nv_bits
  import sr_wprot_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic [SR_W-1:0] data_i,
  input  logic            commit_i,
  output nv_bits_t        nv_o
);
  nv_bits_t nv_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '{lock: 1'b0, blk: BLK_NONE};
    end else if (capture_i) begin
      pend_q.lock <= data_i[LOCK_BIT];
      pend_q.blk  <= blk_sel_e'(data_i[BLK_HI:BLK_LO]);
    end
  end

  // old protection stays live until the cycle ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       nv_q <= '{lock: 1'b0, blk: BLK_NONE};
    else if (commit_i) nv_q <= pend_q;
  end

  assign nv_o = nv_q;

  assert_bits_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(nv_q));
endmodule

// File: rtl/sr_wprot.sv
module sr_wprot
  import sr_wprot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              arr_start_i,
  input  logic              cyc_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_ni,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o
);
  nv_bits_t nv;
  logic     wip, wel, commit, prot_hit, hw_lock;
  logic     sr_go, arr_go;

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .blk_i (nv.blk),
    .addr_i(addr_i),
    .hit_o (prot_hit)
  );

  assign hw_lock     = nv.lock & ~wp_ni;
  assign sr_wr_ok_o  = wel & ~wip & ~hw_lock;
  assign arr_wr_ok_o = wel & ~wip & ~prot_hit;
  assign sr_go       = sr_wr_req_i & sr_wr_ok_o;
  assign arr_go      = arr_start_i & arr_wr_ok_o & ~sr_go;

  sr_cycle_ctrl u_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wren_i  (wren_i),
    .wrdi_i  (wrdi_i),
    .sr_go_i (sr_go),
    .arr_go_i(arr_go),
    .done_i  (cyc_done_i),
    .wip_o   (wip),
    .wel_o   (wel),
    .commit_o(commit)
  );

  sr_nv_bits u_nv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(sr_go),
    .data_i   (sr_wr_data_i),
    .commit_i (commit),
    .nv_o     (nv)
  );

  assign status_o = {nv.lock, 3'b000, nv.blk, wel, wip};

  assert_hw_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[LOCK_BIT] && !wp_ni) |-> !sr_wr_ok_o);
  assert_whole_array_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BLK_HI:BLK_LO] == 2'b11) |-> !arr_wr_ok_o);
  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> (!arr_wr_ok_o && !sr_wr_ok_o));
  assert_rejected_sr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_req_i && !sr_wr_ok_o && !arr_wr_ok_o && !status_o[0]) |=> !status_o[0]);
endmodule

// File: tb/sr_wprot_test.sv
`timescale 1ns/1ps
module sr_wprot_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wren, wrdi, srreq, arrst, done, wpn;
  logic [7:0]  sdata;
  logic [15:0] addr;
  logic [7:0]  status;
  logic        arr_ok, sr_ok;

  always #4 clk = ~clk;

  sr_wprot #(.ADDR_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wren_i(wren), .wrdi_i(wrdi),
    .sr_wr_req_i(srreq), .sr_wr_data_i(sdata), .arr_start_i(arrst),
    .cyc_done_i(done), .addr_i(addr), .wp_ni(wpn),
    .status_o(status), .arr_wr_ok_o(arr_ok), .sr_wr_ok_o(sr_ok)
  );

  typedef struct {
    logic [7:0] st;
    logic       aok;
    logic       sok;
    string      req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // reference state, from the requirements
  logic       m_lock, m_wel, m_wip, m_kind_sr;
  logic [1:0] m_blk, p_blk;
  logic       p_lock;

  function automatic logic hit(logic [1:0] b, logic [15:0] a);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a >= 16'hC000;
      2'b10: return a >= 16'h8000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic exp_t mk(string r, logic [15:0] a, logic w);
    exp_t e;
    e.st  = {m_lock, 3'b000, m_blk, m_wel, m_wip};
    e.aok = m_wel & ~m_wip & ~hit(m_blk, a);
    e.sok = m_wel & ~m_wip & ~(m_lock & ~w);
    e.req = r;
    return e;
  endfunction

  task automatic step(input logic i_wren, input logic i_wrdi, input logic i_sr,
                      input logic [7:0] i_d, input logic i_arr, input logic i_done,
                      input logic [15:0] i_a, input logic i_wp, input string r);
    logic sok, aok, sgo, ago, fin;
    @(negedge clk);
    wren = i_wren; wrdi = i_wrdi; srreq = i_sr; sdata = i_d;
    arrst = i_arr; done = i_done; addr = i_a; wpn = i_wp;
    sok = m_wel & ~m_wip & ~(m_lock & ~i_wp);
    aok = m_wel & ~m_wip & ~hit(m_blk, i_a);
    sgo = i_sr & sok;
    ago = i_arr & aok & ~sgo;
    fin = m_wip & i_done;
    @(posedge clk);
    #1;
    if (fin && m_kind_sr) begin m_lock = p_lock; m_blk = p_blk; end
    if (sgo) begin p_lock = i_d[7]; p_blk = i_d[3:2]; end
    if (fin || i_wrdi) m_wel = 1'b0;
    else if (i_wren && !m_wip) m_wel = 1'b1;
    if (m_wip) begin if (i_done) m_wip = 1'b0; end
    else if (sgo) begin m_wip = 1'b1; m_kind_sr = 1'b1; end
    else if (ago) begin m_wip = 1'b1; m_kind_sr = 1'b0; end
    q.push_back(mk(r, i_a, i_wp));
    wren = 0; wrdi = 0; srreq = 0; arrst = 0; done = 0;
  endtask

  task automatic idle(input logic [15:0] a, input logic w, input string r);
    step(0, 0, 0, 8'h00, 0, 0, a, w, r);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (status !== e.st || arr_ok !== e.aok || sr_ok !== e.sok) begin
          bad++;
          $display("FAIL %s status=%h/%h arr_ok=%b/%b sr_ok=%b/%b",
                   e.req, status, e.st, arr_ok, e.aok, sr_ok, e.sok);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wren = 0; wrdi = 0; srreq = 0; sdata = 0; arrst = 0; done = 0;
    addr = 16'h0000; wpn = 1'b1;
    m_lock = 0; m_blk = 0; m_wel = 0; m_wip = 0; m_kind_sr = 0; p_lock = 0; p_blk = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    idle(16'h0000, 1, "R1 reset");
    // R2 latch control
    step(1, 0, 0, 8'h00, 0, 0, 16'h0000, 1, "R2 wren sets latch");
    step(0, 1, 0, 8'h00, 0, 0, 16'h0000, 1, "R2 wrdi clears latch");
    step(1, 1, 0, 8'h00, 0, 0, 16'h0000, 1, "R2 wrdi beats wren");
    // R5 status write without latch
    step(0, 0, 1, 8'hFF, 0, 0, 16'h0000, 1, "R5 no latch");
    step(0, 0, 0, 8'h00, 0, 1, 16'h0000, 1, "R8 done while idle");
    // R4 status write, old bits held during cycle
    step(1, 0, 0, 8'h00, 0, 0, 16'h0000, 1, "R2 wren");
    step(0, 0, 1, 8'hFF, 0, 0, 16'hF000, 1, "R4 R10 accepted, busy");
    idle(16'hF000, 1, "R10 read during cycle");
    idle(16'hF000, 1, "R4 old bits held");
    step(0, 0, 0, 8'h00, 0, 1, 16'hF000, 1, "R4 R8 commit lock/blk");
    // R3 hardware lock
    step(1, 0, 0, 8'h00, 0, 0, 16'h0000, 0, "R3 R6 locked, whole array");
    step(0, 0, 1, 8'h00, 0, 0, 16'h0000, 0, "R5 rejected under lock");
    idle(16'h0000, 0, "R5 status unchanged");
    // R9 leave lock via pin
    idle(16'h0000, 1, "R9 pin high permits");
    step(0, 0, 1, 8'h04, 0, 0, 16'h0000, 1, "R4 quarter pending");
    step(1, 0, 0, 8'h00, 0, 0, 16'h0000, 1, "R2 wren ignored while busy");
    step(0, 0, 0, 8'h00, 0, 1, 16'h0000, 1, "R8 commit quarter");
    // R6 quarter range
    step(1, 0, 0, 8'h00, 0, 0, 16'hBFFF, 1, "R6 below quarter");
    idle(16'hC000, 1, "R6 quarter start");
    idle(16'hFFFF, 1, "R6 quarter end");
    step(0, 0, 0, 8'h00, 1, 0, 16'hC000, 1, "R7 protected start ignored");
    step(0, 0, 0, 8'h00, 1, 0, 16'h1234, 1, "R7 array start");
    step(0, 1, 0, 8'h00, 0, 0, 16'h1234, 1, "R2 wrdi while busy");
    step(0, 0, 0, 8'h00, 0, 1, 16'h1234, 1, "R8 array done");
    // R6 half range
    step(1, 0, 0, 8'h00, 0, 0, 16'h0000, 1, "R2 wren");
    step(0, 0, 1, 8'h08, 0, 0, 16'h0000, 1, "R4 half pending");
    step(0, 0, 0, 8'h00, 0, 1, 16'h0000, 1, "R8 commit half");
    step(1, 0, 0, 8'h00, 0, 0, 16'h7FFF, 1, "R6 below half");
    idle(16'h8000, 1, "R6 half start");
    // R7 priority: status write beats array start
    step(0, 0, 1, 8'h00, 1, 0, 16'h0100, 1, "R7 status wins");
    step(0, 0, 0, 8'h00, 0, 1, 16'h0100, 1, "R8 commit none");
    idle(16'hFFFF, 1, "R1 final");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule